// File: doc/BRIEF.md
# Retire-Gated Store Commit Queue

This block sits between a core's execution pipeline and its private data cache. A store enters the queue in the cycle it executes, carrying a byte of data and its address. The core later sends one retire pulse per store, oldest first. Until a store has retired it is speculative, and it never leaves the queue. If a fault or a mispredicted branch occurs, a flush throws away every speculative entry. Retired entries stay in the queue and are written later.

Only the oldest entry can be committed. It is written through the cache write port when two conditions hold: it has retired, and the core holds exclusive ownership of the cache line that contains its address. If the core does not own that line, the queue raises an ownership request for it and waits for the grant. Ownership stays held across consecutive stores to the same line until the coherence side revokes it. Because commits happen strictly in allocation order, the core sees its own stores in program order.

Top module: `store_commit_queue`

## Requirements
- R1: After reset the queue is empty, `alloc_ready` is 1, and `wr_valid` and `own_req` are both 0.
- R2: An entry that has not retired never appears on the write port and never raises an ownership request, however long it stays queued.
- R3: Each retire pulse marks the oldest unretired entry. A pulse that arrives when no unretired entry exists has no effect.
- R4: A flush discards every unretired entry, and any allocation offered in the same cycle is dropped. Entries that retired before or in the flush cycle are kept and are committed later.
- R5: When the head entry has retired and its line (address shifted right by `LINE_OFS`) is not owned, `own_req` is 1 and `own_line` carries that line, while `wr_valid` stays 0. Ownership is taken when `own_grant` is 1 during a request. `own_revoke` removes ownership, so `wr_valid` falls and a new request is raised.
- R6: Writes leave the queue in allocation order. While `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold steady.
- R7: With `DEPTH` entries present, `alloc_ready` is 0. An allocation and a commit may take place in the same cycle.
- R8: While ownership of a line is held, further retired stores to that line commit without a new ownership request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | A store executes this cycle |
| alloc_addr | input | ADDR_W | Byte address of the executing store |
| alloc_data | input | DATA_W | Store data |
| alloc_ready | output | 1 | Queue has a free entry |
| retire | input | 1 | One store retires (oldest unretired) |
| flush | input | 1 | Discard all unretired entries |
| own_req | output | 1 | Request exclusive ownership of `own_line` |
| own_line | output | ADDR_W-LINE_OFS | Line of the head entry |
| own_grant | input | 1 | Ownership granted for the requested line |
| own_revoke | input | 1 | Held ownership is taken away |
| wr_valid | output | 1 | Head entry is being written to the cache |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| wr_ready | input | 1 | Cache accepts the write this cycle |

## Verification
The bench builds the queue with `DEPTH`=4, `ADDR_W`=12 and `LINE_OFS`=4. With a depth of four, the full condition and an allocation during draining can be reached in a handful of stores. With 16-byte lines, runs of stores can be placed on one line to show that ownership is reused, and stores can be spread over several lines to force new requests. Ownership grants are switched on and off by the bench. This lets a retired head entry wait at the ownership stage while a flush, a revoke or write backpressure acts on it.

// File: rtl/scq_pkg.sv
package scq_pkg;
  // Ring index advance for queues whose depth need not be a power of two.
  function automatic int unsigned ring_add(int unsigned idx, int unsigned inc, int unsigned depth);
    return (idx + inc) % depth;
  endfunction

  // Number of entries still speculative.
  function automatic int unsigned spec_count(int unsigned occupied, int unsigned retired);
    return occupied - retired;
  endfunction
endpackage

// File: rtl/scq_ptr_ctrl.sv
module scq_ptr_ctrl
  import scq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             retire,
  input  logic             flush,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] rcnt
);
  logic [IDX_W-1:0] head_q, tail_q, head_n, tail_n;
  logic [CNT_W-1:0] cnt_q, rcnt_q, cnt_n, rcnt_n;
  logic             ret_fire;

  assign ret_fire = retire && (spec_count(32'(cnt_q), 32'(rcnt_q)) != 0);

  always_comb begin
    head_n = IDX_W'(ring_add(32'(head_q), 32'(pop), DEPTH));
    rcnt_n = rcnt_q + CNT_W'(ret_fire) - CNT_W'(pop);
    if (flush) begin
      cnt_n  = rcnt_n;
      tail_n = IDX_W'(ring_add(32'(head_n), 32'(rcnt_n), DEPTH));
    end else begin
      cnt_n  = cnt_q + CNT_W'(push) - CNT_W'(pop);
      tail_n = IDX_W'(ring_add(32'(tail_q), 32'(push), DEPTH));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      rcnt_q <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
      cnt_q  <= cnt_n;
      rcnt_q <= rcnt_n;
    end
  end

  assign head_idx = head_q;
  assign tail_idx = tail_q;
  assign cnt      = cnt_q;
  assign rcnt     = rcnt_q;
endmodule

// File: rtl/scq_entry_ram.sv
module scq_entry_ram #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      addr_mem[widx] <= waddr;
      data_mem[widx] <= wdata;
    end
  end

  assign raddr = addr_mem[ridx];
  assign rdata = data_mem[ridx];
endmodule

// File: rtl/scq_line_owner.sv
module scq_line_owner #(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_ret,
  input  logic [LINE_W-1:0] head_line,
  input  logic              grant,
  input  logic              revoke,
  output logic              own_req,
  output logic              may_write,
  output logic              held,
  output logic [LINE_W-1:0] held_line
);
  logic              held_q;
  logic [LINE_W-1:0] line_q;
  logic              line_hit;

  assign line_hit  = held_q && (line_q == head_line);
  assign own_req   = head_ret && !line_hit;
  assign may_write = head_ret && line_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      line_q <= '0;
    end else if (revoke) begin
      held_q <= 1'b0;
    end else if (own_req && grant) begin
      held_q <= 1'b1;
      line_q <= head_line;
    end
  end

  assign held      = held_q;
  assign held_line = line_q;
endmodule

// File: rtl/store_commit_queue.sv
module store_commit_queue #(
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 8,
  parameter int LINE_OFS = 6,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int LINE_W  = ADDR_W - LINE_OFS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [DATA_W-1:0] alloc_data,
  output logic              alloc_ready,
  input  logic              retire,
  input  logic              flush,
  output logic              own_req,
  output logic [LINE_W-1:0] own_line,
  input  logic              own_grant,
  input  logic              own_revoke,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ready
);
  logic              push, pop, head_ret, may_write;
  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic [CNT_W-1:0]  cnt, rcnt;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_data;
  logic [LINE_W-1:0] head_line;
  logic              held;
  logic [LINE_W-1:0] held_line;

  assign alloc_ready = (cnt != CNT_W'(DEPTH));
  assign push        = alloc_valid && alloc_ready && !flush;
  assign head_ret    = (rcnt != '0);
  assign pop         = wr_valid && wr_ready;
  assign head_line   = head_addr[ADDR_W-1:LINE_OFS];

  scq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .retire(retire),
    .flush(flush), .head_idx(head_idx), .tail_idx(tail_idx), .cnt(cnt), .rcnt(rcnt)
  );

  scq_entry_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(push), .widx(tail_idx), .waddr(alloc_addr), .wdata(alloc_data),
    .ridx(head_idx), .raddr(head_addr), .rdata(head_data)
  );

  scq_line_owner #(.LINE_W(LINE_W)) u_own (
    .clk(clk), .rst_n(rst_n), .head_ret(head_ret), .head_line(head_line),
    .grant(own_grant), .revoke(own_revoke), .own_req(own_req),
    .may_write(may_write), .held(held), .held_line(held_line)
  );

  assign own_line = head_line;
  assign wr_valid = may_write;
  assign wr_addr  = head_addr;
  assign wr_data  = head_data;
endmodule

// File: rtl/scq_checker.sv
module scq_checker #(
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 8,
  parameter int LINE_OFS = 6,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int LINE_W  = ADDR_W - LINE_OFS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              alloc_ready,
  input logic              own_req,
  input logic [LINE_W-1:0] own_line,
  input logic              own_revoke,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  rcnt,
  input logic              held,
  input logic [LINE_W-1:0] held_line
);
  a_r2_write_only_retired: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> rcnt != '0);

  a_r2_request_only_retired: assert property (@(posedge clk) disable iff (!rst_n)
    own_req |-> rcnt != '0);

  a_r3_retired_within_occupied: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= cnt);

  a_r4_flush_leaves_retired_only: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt == rcnt);

  a_r5_write_needs_owned_line: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> held && held_line == wr_addr[ADDR_W-1:LINE_OFS]);

  a_r6_stall_holds_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !own_revoke) |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH) && (cnt == CNT_W'(DEPTH) -> !alloc_ready));

  a_r8_no_request_for_held_line: assert property (@(posedge clk) disable iff (!rst_n)
    own_req |-> !(held && held_line == own_line));
endmodule

bind store_commit_queue scq_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_OFS(LINE_OFS)
) u_scq_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_ready(alloc_ready),
  .own_req(own_req), .own_line(own_line), .own_revoke(own_revoke),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .cnt(cnt), .rcnt(rcnt), .held(held), .held_line(held_line)
);

// File: tb/tb_store_commit_queue.sv
`timescale 1ns/1ps
module tb_store_commit_queue;
  localparam int DEPTH = 4, AW = 12, DW = 8, LOFS = 4, LW = AW - LOFS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, retire = 0, flush = 0, own_grant = 0, own_revoke = 0, wr_ready = 0;
  logic [AW-1:0] alloc_addr = '0;
  logic [DW-1:0] alloc_data = '0;
  logic alloc_ready, own_req, wr_valid;
  logic [LW-1:0] own_line;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  always #4 clk = ~clk;

  store_commit_queue #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .LINE_OFS(LOFS)) dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_addr(alloc_addr),
    .alloc_data(alloc_data), .alloc_ready(alloc_ready), .retire(retire), .flush(flush),
    .own_req(own_req), .own_line(own_line), .own_grant(own_grant), .own_revoke(own_revoke),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready)
  );

  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } item_t;
  item_t pending[$];
  item_t expect_q[$];
  int errors = 0, checks = 0, writes = 0, grants = 0;
  bit gnt_en = 0, bench_own = 0;
  logic [LW-1:0] bench_line = '0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Ownership responder: grant the requested line one cycle at a time.
  always @(negedge clk) begin
    own_grant = gnt_en && own_req;
    if (own_grant) begin
      bench_own = 1;
      bench_line = own_line;
      grants++;
    end
  end

  // Scoreboard monitor: compare every accepted write against the model.
  always @(negedge clk) begin
    #2;
    if (rst_n && wr_valid && wr_ready) begin
      item_t e;
      writes++;
      if (expect_q.size() == 0) begin
        check(0, "R2", "write with no retired store", int'(wr_addr), 0);
      end else begin
        e = expect_q.pop_front();
        check(wr_addr == e.a, "R6", "write address order", int'(wr_addr), int'(e.a));
        check(wr_data == e.d, "R6", "write data order", int'(wr_data), int'(e.d));
        check(bench_own && bench_line == (wr_addr >> LOFS), "R5", "write without owned line",
              int'(wr_addr >> LOFS), int'(bench_line));
      end
    end
  end

  task automatic end_cycle();
    @(posedge clk); #1;
    alloc_valid = 0; retire = 0; flush = 0; own_revoke = 0;
  endtask

  task automatic do_alloc(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    alloc_valid = 1; alloc_addr = a; alloc_data = d;
    if (alloc_ready) pending.push_back('{a: a, d: d});
    end_cycle();
  endtask

  task automatic do_alloc_flush(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    alloc_valid = 1; alloc_addr = a; alloc_data = d; flush = 1;
    pending.delete();
    end_cycle();
  endtask

  task automatic do_retire();
    @(negedge clk);
    retire = 1;
    if (pending.size() > 0) expect_q.push_back(pending.pop_front());
    end_cycle();
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1;
    pending.delete();
    end_cycle();
  endtask

  task automatic do_revoke();
    @(negedge clk);
    own_revoke = 1;
    bench_own = 0;
    end_cycle();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) end_cycle();
  endtask

  task automatic drain(string req);
    for (int i = 0; i < 300; i++) begin
      if (expect_q.size() == 0) break;
      end_cycle();
    end
    check(expect_q.size() == 0, req, "retired stores not drained", expect_q.size(), 0);
    idle(2);
  endtask

  initial begin
    #800000;
    check(0, "R6", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int g0;
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    check(alloc_ready == 1, "R1", "alloc_ready after reset", alloc_ready, 1);
    check(wr_valid == 0, "R1", "wr_valid after reset", wr_valid, 0);
    check(own_req == 0, "R1", "own_req after reset", own_req, 0);

    gnt_en = 1; wr_ready = 1;
    // R2: unretired stores stay invisible
    do_alloc(12'h120, 8'h11);
    do_alloc(12'h124, 8'h22);
    do_alloc(12'h130, 8'h33);
    idle(8);
    check(writes == 0, "R2", "writes of unretired stores", writes, 0);
    check(own_req == 0, "R2", "request for unretired store", own_req, 0);

    // R3: two retires commit the two oldest
    do_retire();
    do_retire();
    drain("R3");
    check(writes == 2, "R3", "writes after two retires", writes, 2);

    // R4: flush drops the third store and a same-cycle allocation; R3 spare retire ignored
    do_alloc_flush(12'h200, 8'h44);
    do_retire();
    idle(6);
    check(writes == 2, "R4", "writes after flush", writes, 2);
    do_alloc(12'h140, 8'h55);
    do_retire();
    drain("R4");
    check(writes == 3, "R4", "writes after new store", writes, 3);

    // R5: retired head waits for ownership; R4 it survives a flush
    gnt_en = 0;
    do_alloc(12'h300, 8'h66);
    do_alloc(12'h310, 8'h77);
    do_retire();
    do_flush();
    idle(3);
    check(own_req == 1, "R5", "request raised", own_req, 1);
    check(own_line == 8'h30, "R5", "requested line", int'(own_line), 'h30);
    check(wr_valid == 0, "R5", "write before grant", wr_valid, 0);
    gnt_en = 1;
    drain("R4");
    check(writes == 4, "R4", "retired store kept through flush", writes, 4);

    // R7 full queue; R8 one grant covers a run on one line
    gnt_en = 0;
    for (int i = 0; i < 4; i++) do_alloc(12'h400 + 12'(i), 8'h80 + 8'(i));
    check(alloc_ready == 0, "R7", "alloc_ready when full", alloc_ready, 0);
    do_alloc(12'h404, 8'h84);
    for (int i = 0; i < 4; i++) do_retire();
    g0 = grants;
    gnt_en = 1;
    for (int i = 0; i < 50; i++) begin
      if (writes > 4) break;
      end_cycle();
    end
    do_alloc(12'h405, 8'h90);
    do_retire();
    drain("R7");
    check(writes == 9, "R7", "writes after full run", writes, 9);
    check(grants - g0 == 1, "R8", "grants for one line", grants - g0, 1);

    // R6 backpressure holds the write; R5 revoke withdraws it
    wr_ready = 0;
    do_alloc(12'h500, 8'hA1);
    do_retire();
    idle(4);
    check(wr_valid == 1, "R6", "write offered under stall", wr_valid, 1);
    check(wr_addr == 12'h500, "R6", "stalled address", int'(wr_addr), 'h500);
    idle(2);
    check(wr_data == 8'hA1, "R6", "stalled data", int'(wr_data), 'hA1);
    gnt_en = 0;
    g0 = grants;
    do_revoke();
    idle(1);
    check(wr_valid == 0, "R5", "write after revoke", wr_valid, 0);
    check(own_req == 1, "R5", "request after revoke", own_req, 1);
    gnt_en = 1; wr_ready = 1;
    drain("R5");
    check(grants - g0 == 1, "R5", "regrant after revoke", grants - g0, 1);
    check(writes == 10, "R6", "final write count", writes, 10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule